// File: doc/BRIEF.md
# Multi-Channel Match Timer Bank

This block holds eight match timer channels, numbered 4 to 11. Each channel owns a 32-bit counter, a 32-bit match value and a control word. The control word picks which of four tick strobes advances the counter, what happens when a match occurs, and which counter the channel compares against. A channel can use its own counter, or it can compare against the counter of the base channel of its group. The groups are: channels 5 to 7 with counter 4, channel 9 with counter 8, and channel 11 with counter 10.

A match sets a per-channel status flag if that channel's interrupt enable is set. All status flags drive one shared, level-type interrupt. Software clears the flags by writing ones. Reading counter 9 or counter 11 can also latch the partner counter (8 or 10) into a snapshot register, so a pair of counters can be sampled coherently.

Software reaches every register through a simple single-cycle read and write port. The address on this port is a word index, which is the byte offset divided by four. Read data is combinational, and any read side effect takes place at the clock edge that ends the read cycle.

Top module: `match_timer_bank`

## Requirements
- R1: After a synchronous active-low reset, every counter, match, control, enable, status and snapshot register reads zero, and `irq` is low.
- R2: A channel's counter advances by one on each clock in which its selected strobe is high. The selection uses control bits [2:0]: 1 selects `tick_32k`, 2 selects `tick_1k`, 3 selects `tick_1hz` and 4 selects `tick_1m`. Codes 0 and 5 to 7 hold the counter. Only a channel using its own counter advances it.
- R3: A match happens on the clock where the compared counter advances to a value equal to the channel's match register. With control bit 3 set, a match on a channel that uses its own counter loads that counter with zero instead of the matched value.
- R4: With control bit 6 clear, a channel matches only once. It is re-armed by a write to its match register (word 0x20+n-4) or its counter register (word 0x10+n-4). With bit 6 set, it matches every time.
- R5: Control bit 7 set makes a channel use its own counter. When bit 7 is clear, channels 5 to 7 compare against counter 4, channel 9 against counter 8 and channel 11 against counter 10, and their own counters hold. Channels 4, 8 and 10 always use their own counters.
- R6: A control write (word 0x30+n-4) keeps bits [7:0] for channels 4 to 7 and bits [9:0] for channels 8 to 11. On channels 8 to 11, control bit 8 holds the channel's own counter.
- R7: A match on channel n sets status bit n (status word 0x05, bits 4 to 11) only when bit n of the enable word (0x07) is set. Writes to the enable word keep bits 11:4.
- R8: `irq` is high while any status bit 4 to 11 is set. Writing a one to a status bit clears it, and `irq` falls only when no status bit remains set.
- R9: When control bit 9 of channel 9 (or 11) is set, a read of that channel's counter copies the current value of counter 8 (or 10) into the snapshot word (0x08). No other action changes the snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Word index of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the read cycle |
| tick_32k | input | 1 | 32.768 kHz tick, one-cycle pulse |
| tick_1k | input | 1 | 1 kHz tick, one-cycle pulse |
| tick_1hz | input | 1 | 1 Hz tick, one-cycle pulse |
| tick_1m | input | 1 | 1 MHz tick, one-cycle pulse |
| irq | output | 1 | Shared interrupt level |

## Verification
Errors in the armed flags, the counter source choice or the enable gating can only be seen when a match does or does not raise `irq`. That shows one clock after the deciding tick, so each scenario counts pulses to exactly the match value and then checks both the status word and `irq`. A wrong clear-on-match, a wrong stop decode or a wrong control mask leaves a counter or control value off by a known amount, and an immediate read exposes it. A snapshot fault stays hidden until the snapshot word is read after the trigger read. The bench therefore reads that word straight after every trigger read and after every read that must not trigger.

// File: rtl/mtb_pkg.sv
// Package: shared constants and channel-group helpers for the match timer bank.
// Assumes eight channels numbered FIRST_CH..FIRST_CH+7 with fixed group bases.
package mtb_pkg;
    localparam int FIRST_CH   = 4;
    localparam int NUM_CH     = 8;
    localparam int CTRL_W     = 10;
    localparam int ADDR_W     = 6;

    localparam logic [ADDR_W-1:0] A_STATUS = 6'h05;
    localparam logic [ADDR_W-1:0] A_ENABLE = 6'h07;
    localparam logic [ADDR_W-1:0] A_SNAP   = 6'h08;
    localparam logic [2:0]        R_COUNT  = 3'b010;
    localparam logic [2:0]        R_MATCH  = 3'b100;
    localparam logic [2:0]        R_CTRL   = 3'b110;

    // Local indices of the snapshot trigger channels and their partners.
    localparam int SNAP_A = 5;
    localparam int SNAP_B = 7;

    // Control bit positions.
    localparam int B_CLR  = 3;
    localparam int B_PER  = 6;
    localparam int B_OWN  = 7;
    localparam int B_STOP = 8;
    localparam int B_SNAP = 9;

    // Local index of the group base counter for channel c.
    function automatic int base_of(input int c);
        if (c >= 6) return 6;
        if (c >= 4) return 4;
        return 0;
    endfunction

    // Base channels always use their own counter.
    function automatic bit is_base(input int c);
        return (c == 0) || (c == 4) || (c == 6);
    endfunction
endpackage

// File: rtl/mtb_counter.sv
// Module: one channel counter with tick selection, load and clear-on-match.
// Assumes tick strobes are single-cycle pulses; load takes priority.
module mtb_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [3:0]   ticks,
    input  logic [2:0]   code,
    input  logic         run_en,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         clr,
    output logic [W-1:0] cnt,
    output logic         adv,
    output logic [W-1:0] nxt
);
    logic sel_tick;

    // Pick the strobe named by the source code; other codes hold.
    always_comb begin
        case (code)
            3'd1:    sel_tick = ticks[0];
            3'd2:    sel_tick = ticks[1];
            3'd3:    sel_tick = ticks[2];
            3'd4:    sel_tick = ticks[3];
            default: sel_tick = 1'b0;
        endcase
    end

    assign adv = run_en && sel_tick && !ld;
    assign nxt = cnt + 1'b1;

    // Counter register: load, clear on match, or advance.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (ld)      cnt <= ld_val;
        else if (adv)     cnt <= clr ? '0 : nxt;
    end
endmodule

// File: rtl/mtb_compare.sv
// Module: match detector with one-shot arming for one channel.
// Assumes the source counter's advance flag and next value are given.
module mtb_compare #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         src_adv,
    input  logic [W-1:0] src_nxt,
    input  logic [W-1:0] match_val,
    input  logic         periodic,
    input  logic         rearm,
    output logic         hit,
    output logic         armed
);
    assign hit = armed && src_adv && (src_nxt == match_val);

    // Arming flag: set by rewrite, dropped by a one-shot match.
    always_ff @(posedge clk) begin
        if (!rst_n)                 armed <= 1'b1;
        else if (rearm)             armed <= 1'b1;
        else if (hit && !periodic)  armed <= 1'b0;
    end
endmodule

// File: rtl/match_timer_bank.sv
// Module: top of the match timer bank; register decode, channels, status,
// snapshot and shared interrupt. Assumes word addressing and one access
// per cycle; read data is combinational.
module match_timer_bank
    import mtb_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      rdata,
    input  logic              tick_32k,
    input  logic              tick_1k,
    input  logic              tick_1hz,
    input  logic              tick_1m,
    output logic              irq
);
    localparam int HI = FIRST_CH + NUM_CH;

    logic [NUM_CH-1:0][W-1:0]      cnt_q;
    logic [NUM_CH-1:0][W-1:0]      nxt;
    logic [NUM_CH-1:0][W-1:0]      match_q;
    logic [NUM_CH-1:0][CTRL_W-1:0] ctrl_q;
    logic [NUM_CH-1:0]             adv;
    logic [NUM_CH-1:0]             hit;
    logic [NUM_CH-1:0]             armed;
    logic [NUM_CH-1:0]             own_sel;
    logic [NUM_CH-1:0]             status_q;
    logic [NUM_CH-1:0]             ier_q;
    logic [W-1:0]                  snap_q;
    logic [3:0]                    ticks;
    logic [2:0]                    region;
    logic [2:0]                    idx;

    assign ticks  = {tick_1m, tick_1hz, tick_1k, tick_32k};
    assign region = addr[5:3];
    assign idx    = addr[2:0];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int          BASE  = base_of(c);
        localparam bit          ALWAYS_OWN = is_base(c);
        localparam int          KEEP  = (c < 4) ? 8 : CTRL_W;
        localparam logic [CTRL_W-1:0] MASK = CTRL_W'((1 << KEEP) - 1);

        logic ld_cnt, ld_match, ld_ctrl, stop, run_en, clr, src_adv;
        logic [W-1:0] src_nxt;

        assign ld_cnt   = wr_en && region == R_COUNT && idx == 3'(c);
        assign ld_match = wr_en && region == R_MATCH && idx == 3'(c);
        assign ld_ctrl  = wr_en && region == R_CTRL  && idx == 3'(c);
        assign own_sel[c] = ALWAYS_OWN || ctrl_q[c][B_OWN];
        assign stop     = (c >= 4) && ctrl_q[c][B_STOP];
        assign run_en   = own_sel[c] && !stop;
        assign src_adv  = own_sel[c] ? adv[c] : adv[BASE];
        assign src_nxt  = own_sel[c] ? nxt[c] : nxt[BASE];
        assign clr      = hit[c] && ctrl_q[c][B_CLR] && own_sel[c];

        mtb_counter #(.W(W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .ticks(ticks),
            .code(ctrl_q[c][2:0]), .run_en(run_en),
            .ld(ld_cnt), .ld_val(wdata), .clr(clr),
            .cnt(cnt_q[c]), .adv(adv[c]), .nxt(nxt[c])
        );

        mtb_compare #(.W(W)) u_cmp (
            .clk(clk), .rst_n(rst_n), .src_adv(src_adv),
            .src_nxt(src_nxt), .match_val(match_q[c]),
            .periodic(ctrl_q[c][B_PER]), .rearm(ld_cnt || ld_match),
            .hit(hit[c]), .armed(armed[c])
        );

        // Match and control registers of this channel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                match_q[c] <= '0;
                ctrl_q[c]  <= '0;
            end else begin
                if (ld_match) match_q[c] <= wdata;
                if (ld_ctrl)  ctrl_q[c]  <= wdata[CTRL_W-1:0] & MASK;
            end
        end
    end

    // Enable word: keeps only the channel bits.
    always_ff @(posedge clk) begin
        if (!rst_n)                        ier_q <= '0;
        else if (wr_en && addr == A_ENABLE) ier_q <= wdata[HI-1:FIRST_CH];
    end

    // Status flags: enabled matches set, written ones clear; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else status_q <= (status_q &
                          ~((wr_en && addr == A_STATUS) ? wdata[HI-1:FIRST_CH] : '0))
                         | (hit & ier_q);
    end

    // Snapshot: a flagged counter read latches the partner counter.
    always_ff @(posedge clk) begin
        if (!rst_n) snap_q <= '0;
        else if (rd_en && region == R_COUNT) begin
            if (idx == 3'(SNAP_A) && ctrl_q[SNAP_A][B_SNAP])
                snap_q <= cnt_q[SNAP_A-1];
            else if (idx == 3'(SNAP_B) && ctrl_q[SNAP_B][B_SNAP])
                snap_q <= cnt_q[SNAP_B-1];
        end
    end

    assign irq = |status_q;

    // Read multiplexer over all register regions.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (region)
                R_COUNT: rdata = cnt_q[idx];
                R_MATCH: rdata = match_q[idx];
                R_CTRL:  rdata = W'(ctrl_q[idx]);
                default: begin
                    if (addr == A_STATUS)      rdata = W'({status_q, 4'b0});
                    else if (addr == A_ENABLE) rdata = W'({ier_q, 4'b0});
                    else if (addr == A_SNAP)   rdata = snap_q;
                end
            endcase
        end
    end
endmodule

// File: rtl/mtb_checker.sv
// Module: temporal checks for the match timer bank, bound to the top.
// Assumes reset is held for at least one clock at start.
module mtb_checker
    import mtb_pkg::*;
#(
    parameter int W = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      wr_en,
    input logic                      rd_en,
    input logic [ADDR_W-1:0]         addr,
    input logic [NUM_CH-1:0]         hit,
    input logic [NUM_CH-1:0]         armed,
    input logic [NUM_CH-1:0][CTRL_W-1:0] ctrl_q,
    input logic [NUM_CH-1:0]         ier_q,
    input logic [NUM_CH-1:0]         status_q,
    input logic [W-1:0]              snap_q,
    input logic                      irq
);
    // R7: a newly set status bit needs its enable bit in the prior cycle.
    a_r7_status_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q & ~$past(status_q) & ~$past(ier_q)) == '0);

    // R8: the shared line only falls after a status write.
    a_r8_irq_falls_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(wr_en && addr == A_STATUS));

    // R9: snapshot changes only after a read of a trigger counter.
    a_r9_snapshot_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && (addr == 6'h10 + 6'(SNAP_A) || addr == 6'h10 + 6'(SNAP_B)))
        |=> $stable(snap_q));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        // R4: a one-shot match with no write disarms the channel.
        a_r4_oneshot_disarms: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[c] && !ctrl_q[c][B_PER] && !wr_en) |=> !armed[c]);
    end
endmodule

bind match_timer_bank mtb_checker #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .hit(hit), .armed(armed), .ctrl_q(ctrl_q), .ier_q(ier_q),
    .status_q(status_q), .snap_q(snap_q), .irq(irq)
);

// File: tb/match_timer_bank_test.sv
// Directed bench for the match timer bank; one task per scenario.
module match_timer_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  tk = '0;
    logic        irq;
    int          n_run = 0, n_fail = 0;

    localparam logic [5:0] STAT = 6'h05, IEN = 6'h07, SNAP = 6'h08;

    match_timer_bank uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .tick_32k(tk[0]), .tick_1k(tk[1]), .tick_1hz(tk[2]), .tick_1m(tk[3]),
        .irq(irq)
    );

    always #4 clk = ~clk;

    function automatic logic [5:0] a_cnt(input int ch); return 6'(6'h10 + ch - 4); endfunction
    function automatic logic [5:0] a_mat(input int ch); return 6'(6'h20 + ch - 4); endfunction
    function automatic logic [5:0] a_ctl(input int ch); return 6'(6'h30 + ch - 4); endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic pulse(input logic [3:0] m, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tk = m;
            @(negedge clk); tk = '0;
        end
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(a_cnt(4), v);  chk("R1 counter4", v, 0);
        rd(a_ctl(11), v); chk("R1 ctrl11", v, 0);
        rd(SNAP, v);      chk("R1 snapshot", v, 0);
        rd(STAT, v);      chk("R1 status", v, 0);
        chk("R1 irq", {31'b0, irq}, 0);
    endtask

    task automatic t_tick_select;
        logic [31:0] v;
        wr(a_ctl(4), 32'h1); wr(a_cnt(4), 0);
        pulse(4'b0001, 3); pulse(4'b0010, 2); pulse(4'b1000, 1);
        rd(a_cnt(4), v); chk("R2 32k select", v, 3);
        wr(a_ctl(4), 32'h4); pulse(4'b1000, 2); pulse(4'b0100, 1);
        rd(a_cnt(4), v); chk("R2 1MHz select", v, 5);
        wr(a_ctl(4), 32'h6); pulse(4'b1111, 3);
        rd(a_cnt(4), v); chk("R2 code 6 holds", v, 5);
    endtask

    task automatic t_match_irq;
        logic [31:0] v;
        wr(IEN, 32'h10); wr(a_ctl(4), 32'h1); wr(a_mat(4), 5); wr(a_cnt(4), 0);
        pulse(4'b0001, 4);
        chk("R8 no irq before match", {31'b0, irq}, 0);
        pulse(4'b0001, 1);
        rd(STAT, v); chk("R7 status bit4", v, 32'h10);
        chk("R8 irq on match", {31'b0, irq}, 1);
        wr(STAT, 32'h10);
        chk("R8 irq cleared", {31'b0, irq}, 0);
    endtask

    task automatic t_oneshot_clear;
        logic [31:0] v;
        wr(a_ctl(4), 32'h09); wr(a_mat(4), 3); wr(a_cnt(4), 0);
        pulse(4'b0001, 3);
        rd(a_cnt(4), v); chk("R3 cleared on match", v, 0);
        wr(STAT, 32'h10);
        pulse(4'b0001, 3);
        rd(a_cnt(4), v); chk("R4 one-shot no second clear", v, 3);
        rd(STAT, v);     chk("R4 one-shot no second status", v, 0);
        wr(a_mat(4), 6); pulse(4'b0001, 3);
        rd(a_cnt(4), v); chk("R4 rearm by match write", v, 0);
        rd(STAT, v);     chk("R4 rearmed status", v, 32'h10);
        wr(STAT, 32'h10);
    endtask

    task automatic t_periodic;
        logic [31:0] v;
        wr(a_ctl(4), 32'h49); wr(a_mat(4), 2); wr(a_cnt(4), 0);
        pulse(4'b0001, 2); wr(STAT, 32'h10);
        pulse(4'b0001, 2);
        rd(STAT, v); chk("R4 periodic second match", v, 32'h10);
        wr(STAT, 32'h10);
    endtask

    task automatic t_enable_gate;
        logic [31:0] v;
        wr(IEN, 0); wr(a_ctl(4), 32'h41); wr(a_mat(4), 1); wr(a_cnt(4), 0);
        pulse(4'b0001, 1);
        rd(STAT, v); chk("R7 disabled no status", v, 0);
        chk("R7 disabled no irq", {31'b0, irq}, 0);
    endtask

    task automatic t_borrow;
        logic [31:0] v;
        wr(IEN, 32'h20); wr(a_ctl(4), 32'h1); wr(a_ctl(5), 32'h2);
        wr(a_mat(5), 4); wr(a_cnt(5), 0); wr(a_cnt(4), 0);
        pulse(4'b0001, 4); pulse(4'b0010, 1);
        rd(STAT, v);     chk("R5 ch5 matches counter4", v, 32'h20);
        rd(a_cnt(5), v); chk("R5 borrowed own counter holds", v, 0);
        wr(STAT, 32'h20);
        wr(a_ctl(5), 32'h82); pulse(4'b0010, 2);
        rd(a_cnt(5), v); chk("R5 own counter runs", v, 2);
    endtask

    task automatic t_ctrl_bits;
        logic [31:0] v;
        wr(a_ctl(8), 32'h101); wr(a_cnt(8), 0); pulse(4'b0001, 2);
        rd(a_cnt(8), v); chk("R6 stop bit holds ch8", v, 0);
        wr(a_ctl(8), 32'h001); pulse(4'b0001, 2);
        rd(a_cnt(8), v); chk("R6 ch8 runs without stop", v, 2);
        wr(a_ctl(6), 32'h3FF); rd(a_ctl(6), v); chk("R6 ch6 keeps 8 bits", v, 32'hFF);
        wr(a_ctl(9), 32'hFFFF); rd(a_ctl(9), v); chk("R6 ch9 keeps 10 bits", v, 32'h3FF);
        wr(a_ctl(6), 0); wr(a_ctl(9), 0);
    endtask

    task automatic t_snapshot;
        logic [31:0] v;
        wr(a_ctl(8), 0); wr(a_cnt(8), 7); wr(a_ctl(9), 32'h200);
        rd(a_cnt(9), v); rd(SNAP, v); chk("R9 snapshot of counter8", v, 7);
        wr(a_ctl(11), 0); wr(a_cnt(10), 9);
        rd(a_cnt(11), v); rd(SNAP, v); chk("R9 no snapshot without bit9", v, 7);
        wr(a_ctl(11), 32'h200);
        rd(a_cnt(11), v); rd(SNAP, v); chk("R9 snapshot of counter10", v, 9);
    endtask

    task automatic t_shared_irq;
        logic [31:0] v;
        wr(IEN, 32'h50); wr(a_ctl(4), 32'h1); wr(a_ctl(6), 0);
        wr(a_mat(4), 2); wr(a_mat(6), 2); wr(a_cnt(4), 0);
        pulse(4'b0001, 2);
        rd(STAT, v); chk("R8 two status bits", v, 32'h50);
        wr(STAT, 32'h10);
        chk("R8 irq held by bit6", {31'b0, irq}, 1);
        wr(STAT, 32'h40);
        chk("R8 irq low when all clear", {31'b0, irq}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_tick_select;
        t_match_irq;
        t_oneshot_clear;
        t_periodic;
        t_enable_gate;
        t_borrow;
        t_ctrl_bits;
        t_snapshot;
        t_shared_irq;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule